// File: doc/BRIEF.md
# ASID-tagged translation cache

This block caches finished address translations for an I/O memory management unit. Every entry is tagged with a 16-bit address-space identifier (ASID) and with the page-aligned input address. A lookup carries an ASID, an address, a log2 granule size and a read/write flag. A hit returns the cached page address plus the in-page offset of the request, together with the cached address mask, on the cycle after acceptance. A write to a page that is cached without write permission returns a permission fault.

A miss sends a request to an external page-table walker and waits for its reply. A successful reply fills the lowest-indexed free slot and completes the request. A failed reply completes the request with a walk fault and inserts nothing. The cache has no replacement policy. When every slot is valid and a miss is accepted, the whole cache is flushed and the fill then lands in an empty array. Three invalidation inputs remove all entries, the entries of one ASID, or one page of one ASID. Two free-running counters record hits and misses.

Top module: `asid_xlat_cache`

## Requirements
- R1: After reset no entry is valid, both counters read zero, `req_ready` is high and `rsp_valid` and `walk_req_valid` are low.
- R2: A lookup that hits raises `rsp_valid` with `rsp_hit`=1 on the cycle after acceptance. `rsp_addr` equals the cached page address plus `req_addr & (2^req_gran - 1)`, and `rsp_mask` equals the cached mask.
- R3: The tag is the ASID together with `req_addr` with its low `req_gran` bits cleared. Another offset in the same page hits. Another ASID or another page misses.
- R4: `rsp_status` is 0 for success, 1 for a permission fault and 2 for a walk fault. A write to a page whose entry lacks write permission gives 1, on a hit and on a successful fill alike.
- R5: A miss raises `walk_req_valid` with the request ASID, the aligned address and the write flag, and holds `req_ready` low. When `walk_rsp_valid` arrives, the response follows one cycle later with `rsp_hit`=0, and `rsp_addr` is the walked address plus the offset.
- R6: A walk reply with `walk_rsp_err`=1 completes the request with status 2 and inserts nothing, so the same page misses again.
- R7: When all ENTRIES slots are valid and a miss is accepted, every entry is removed before the fill.
- R8: A page invalidation removes only the entry whose ASID and aligned address both match `inv_asid` and `inv_addr`.
- R9: An ASID invalidation removes every entry whose ASID matches `inv_asid` and leaves the other ASIDs cached.
- R10: Invalidate-all removes every entry. If it arrives while a miss is outstanding, the pending fill is discarded, although the request still completes.
- R11: An ASID or page invalidation that arrives while a miss is outstanding does not block the pending fill, so the filled page hits afterwards.
- R12: While `walk_req_ready` is low, `walk_req_valid` stays high with stable ASID and address, and lookups stay blocked.
- R13: A walk response that arrives while no miss is outstanding is ignored. It produces no response, no counter change and no entry.
- R14: Each accepted lookup increments exactly one of `hit_count` or `miss_count`, and no other cycle changes either counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup can be accepted |
| req_asid | input | ASID_W | Lookup ASID |
| req_addr | input | VA_W | Lookup input address |
| req_gran | input | GRAN_W | log2 of the page granule |
| req_write | input | 1 | Lookup is a write |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Response came from the cache |
| rsp_status | output | 2 | 0 ok, 1 permission fault, 2 walk fault |
| rsp_addr | output | PA_W | Translated address |
| rsp_mask | output | PA_W | Address mask of the translation |
| walk_req_valid | output | 1 | Walk request valid |
| walk_req_ready | input | 1 | Walker accepts the request |
| walk_req_asid | output | ASID_W | Walk ASID |
| walk_req_addr | output | VA_W | Walk aligned address |
| walk_req_write | output | 1 | Walk is for a write |
| walk_rsp_valid | input | 1 | Walk reply valid |
| walk_rsp_err | input | 1 | Walk failed |
| walk_rsp_addr | input | PA_W | Walked page address |
| walk_rsp_mask | input | PA_W | Walked address mask |
| walk_rsp_wr_ok | input | 1 | Page allows writes |
| inv_all | input | 1 | Invalidate every entry |
| inv_asid_en | input | 1 | Invalidate entries of `inv_asid` |
| inv_page_en | input | 1 | Invalidate page `inv_addr` of `inv_asid` |
| inv_asid | input | ASID_W | Invalidation ASID |
| inv_addr | input | VA_W | Invalidation aligned address |
| hit_count | output | CNT_W | Hit counter |
| miss_count | output | CNT_W | Miss counter |

## Verification
Most faults in the stored state show up at the ports within a single lookup. A valid bit that does not clear turns an expected miss into a hit with the old address. A lost fill turns a hit back into a miss and advances `miss_count`. A wrong tag or free-slot choice either hides a page or overwrites a neighbour, and the next probe of that neighbour reports it. A pending-state fault, such as a fill that is not discarded or a stray reply that is accepted, shows up one lookup later as a wrong hit/miss bit and a counter that no longer matches the count the bench keeps.

// File: rtl/asid_xlat_cache.sv
module asid_xlat_cache #(
  parameter int ENTRIES = 256,
  parameter int ASID_W  = 16,
  parameter int VA_W    = 48,
  parameter int PA_W    = 48,
  parameter int GRAN_W  = 6,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [VA_W-1:0]   req_addr,
  input  logic [GRAN_W-1:0] req_gran,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_status,
  output logic [PA_W-1:0]   rsp_addr,
  output logic [PA_W-1:0]   rsp_mask,
  output logic              walk_req_valid,
  input  logic              walk_req_ready,
  output logic [ASID_W-1:0] walk_req_asid,
  output logic [VA_W-1:0]   walk_req_addr,
  output logic              walk_req_write,
  input  logic              walk_rsp_valid,
  input  logic              walk_rsp_err,
  input  logic [PA_W-1:0]   walk_rsp_addr,
  input  logic [PA_W-1:0]   walk_rsp_mask,
  input  logic              walk_rsp_wr_ok,
  input  logic              inv_all,
  input  logic              inv_asid_en,
  input  logic              inv_page_en,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [VA_W-1:0]   inv_addr,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [1:0] ST_OK = 2'd0, ST_PERM = 2'd1, ST_WALK = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_WREQ, S_WAIT} state_t;
  state_t st;

  logic [ENTRIES-1:0] vld, vld_nx, hv, clr, d_wr;
  logic [ASID_W-1:0]  t_asid [ENTRIES];
  logic [VA_W-1:0]    t_va   [ENTRIES];
  logic [PA_W-1:0]    d_pa   [ENTRIES];
  logic [PA_W-1:0]    d_mask [ENTRIES];

  logic [ASID_W-1:0] p_asid;
  logic [VA_W-1:0]   p_va;
  logic [PA_W-1:0]   p_off;
  logic              p_write, p_drop;

  logic [PA_W-1:0] h_pa, h_mask;
  logic            h_wr;
  logic [IDX_W-1:0] slot;

  wire [VA_W-1:0] lk_mask = {VA_W{1'b1}} << req_gran;
  wire [VA_W-1:0] lk_va   = req_addr & lk_mask;
  wire [PA_W-1:0] lk_off  = PA_W'(req_addr & ~lk_mask);
  wire accept = req_valid && req_ready;
  wire hit    = |hv;
  wire full   = &vld;
  wire fill   = (st == S_WAIT) && walk_rsp_valid && !walk_rsp_err && !p_drop && !inv_all;

  assign req_ready      = (st == S_IDLE);
  assign walk_req_valid = (st == S_WREQ);
  assign walk_req_asid  = p_asid;
  assign walk_req_addr  = p_va;
  assign walk_req_write = p_write;

  always_comb begin
    h_pa = '0; h_mask = '0; h_wr = 1'b0; slot = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hv[i]  = vld[i] && (t_asid[i] == req_asid) && (t_va[i] == lk_va);
      clr[i] = inv_all || (inv_asid_en && t_asid[i] == inv_asid) ||
               (inv_page_en && t_asid[i] == inv_asid && t_va[i] == inv_addr);
      h_pa   = h_pa   | ({PA_W{hv[i]}} & d_pa[i]);
      h_mask = h_mask | ({PA_W{hv[i]}} & d_mask[i]);
      h_wr   = h_wr   | (hv[i] & d_wr[i]);
    end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) slot = IDX_W'(i);
    vld_nx = vld & ~clr;
    if (accept && !hit && full) vld_nx = '0;
    if (fill) vld_nx[slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      t_asid[slot] <= p_asid;
      t_va[slot]   <= p_va;
      d_pa[slot]   <= walk_rsp_addr;
      d_mask[slot] <= walk_rsp_mask;
      d_wr[slot]   <= walk_rsp_wr_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; st <= S_IDLE; rsp_valid <= 1'b0; rsp_hit <= 1'b0;
      rsp_status <= ST_OK; rsp_addr <= '0; rsp_mask <= '0;
      hit_count <= '0; miss_count <= '0;
      p_asid <= '0; p_va <= '0; p_off <= '0; p_write <= 1'b0; p_drop <= 1'b0;
    end else begin
      vld <= vld_nx;
      rsp_valid <= 1'b0;
      if (st != S_IDLE && inv_all) p_drop <= 1'b1;
      case (st)
        S_IDLE: if (accept) begin
          if (hit) begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= 1'b1;
            rsp_status <= (req_write && !h_wr) ? ST_PERM : ST_OK;
            rsp_addr   <= h_pa + lk_off;
            rsp_mask   <= h_mask;
            hit_count  <= hit_count + 1'b1;
          end else begin
            miss_count <= miss_count + 1'b1;
            p_asid <= req_asid; p_va <= lk_va; p_off <= lk_off;
            p_write <= req_write; p_drop <= 1'b0;
            st <= S_WREQ;
          end
        end
        S_WREQ: if (walk_req_ready) st <= S_WAIT;
        S_WAIT: if (walk_rsp_valid) begin
          rsp_valid  <= 1'b1;
          rsp_hit    <= 1'b0;
          rsp_status <= walk_rsp_err ? ST_WALK :
                        (p_write && !walk_rsp_wr_ok) ? ST_PERM : ST_OK;
          rsp_addr   <= walk_rsp_addr + p_off;
          rsp_mask   <= walk_rsp_mask;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/asid_xlat_cache_chk.sv
module asid_xlat_cache_chk #(
  parameter int ASID_W = 16,
  parameter int VA_W   = 48,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              walk_req_valid,
  input logic              walk_req_ready,
  input logic [ASID_W-1:0] walk_req_asid,
  input logic [VA_W-1:0]   walk_req_addr,
  input logic              walk_rsp_valid,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  a_r5_blocked_during_walk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid |-> !req_ready);

  a_r12_walk_held: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid && !walk_req_ready |=>
      walk_req_valid && $stable(walk_req_asid) && $stable(walk_req_addr));

  a_r2_hit_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> $past(req_valid && req_ready));

  a_r13_miss_rsp_from_walk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> $past(walk_rsp_valid));

  a_r14_counts_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(hit_count) && $stable(miss_count));

  a_r14_counts_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      CNT_W'(hit_count + miss_count) == CNT_W'($past(hit_count) + $past(miss_count) + 1'b1));
endmodule

bind asid_xlat_cache asid_xlat_cache_chk #(.ASID_W(ASID_W), .VA_W(VA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/asid_xlat_cache_bench.sv
module asid_xlat_cache_bench;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [15:0] req_asid = 0;
  logic [47:0] req_addr = 0;
  logic [5:0]  req_gran = 12;
  logic rsp_valid, rsp_hit, req_ready;
  logic [1:0] rsp_status;
  logic [47:0] rsp_addr, rsp_mask;
  logic walk_req_valid, walk_req_write;
  logic walk_req_ready = 1;
  logic [15:0] walk_req_asid;
  logic [47:0] walk_req_addr;
  logic walk_rsp_valid = 0, walk_rsp_err = 0, walk_rsp_wr_ok = 0;
  logic [47:0] walk_rsp_addr = 0, walk_rsp_mask = 0;
  logic inv_all = 0, inv_asid_en = 0, inv_page_en = 0;
  logic [15:0] inv_asid = 0;
  logic [47:0] inv_addr = 0;
  logic [31:0] hit_count, miss_count;

  asid_xlat_cache #(.ENTRIES(N)) u_asid_xlat_cache (.*);

  int checks = 0, bad = 0, exp_hits = 0, exp_miss = 0, wlat = 2;
  logic [47:0] exp_walk_addr;
  logic [15:0] exp_walk_asid;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] gmask(input int g);
    return 48'((64'd1 << g) - 64'd1);
  endfunction

  function automatic logic [47:0] pa_of(input logic [15:0] a, input logic [47:0] va);
    return va ^ {a, 32'h0};
  endfunction

  initial begin : walker
    forever begin
      @(negedge clk);
      if (walk_req_valid && walk_req_ready) begin
        logic [15:0] a;
        logic [47:0] v;
        a = walk_req_asid;
        v = walk_req_addr;
        chk(v == exp_walk_addr && a == exp_walk_asid, "R5 walk request key", {a, v}, {exp_walk_asid, exp_walk_addr});
        @(negedge clk);
        repeat (wlat) @(negedge clk);
        walk_rsp_valid = 1;
        walk_rsp_err   = v[47];
        walk_rsp_addr  = pa_of(a, v);
        walk_rsp_mask  = gmask(int'(req_gran));
        walk_rsp_wr_ok = ~a[0];
        @(negedge clk);
        walk_rsp_valid = 0;
      end
    end
  end

  task automatic do_req(input logic [15:0] a, input logic [47:0] addr, input int g,
                        input logic wr, input logic exp_hit, input string tag);
    logic [47:0] al;
    logic [1:0] es;
    al = addr & ~gmask(g);
    es = (!exp_hit && addr[47]) ? 2'd2 : (wr && a[0]) ? 2'd1 : 2'd0;
    exp_walk_addr = al;
    exp_walk_asid = a;
    @(negedge clk);
    req_valid = 1; req_asid = a; req_addr = addr; req_gran = 6'(g); req_write = wr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (!rsp_valid) chk(!req_ready, {tag, " R5 ready low on miss"}, 64'(req_ready), 64'd0);
    while (!rsp_valid) @(negedge clk);
    if (exp_hit) exp_hits++; else exp_miss++;
    chk(rsp_hit == exp_hit, {tag, " hit"}, 64'(rsp_hit), 64'(exp_hit));
    chk(rsp_status == es, {tag, " R4 status"}, 64'(rsp_status), 64'(es));
    if (es != 2'd2) begin
      chk(rsp_addr == pa_of(a, al) + (addr & gmask(g)), {tag, " R2 addr"}, 64'(rsp_addr), 64'(pa_of(a, al) + (addr & gmask(g))));
      chk(rsp_mask == gmask(g), {tag, " R2 mask"}, 64'(rsp_mask), 64'(gmask(g)));
    end
    chk(hit_count == 32'(exp_hits) && miss_count == 32'(exp_miss), {tag, " R14 counters"},
        {hit_count, miss_count}, {32'(exp_hits), 32'(exp_miss)});
  endtask

  task automatic inv(input logic all, input logic ae, input logic pe, input logic [15:0] a, input logic [47:0] v);
    @(negedge clk);
    inv_all = all; inv_asid_en = ae; inv_page_en = pe; inv_asid = a; inv_addr = v;
    @(negedge clk);
    inv_all = 0; inv_asid_en = 0; inv_page_en = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; checks++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !walk_req_valid, "R1 idle after reset", {req_ready, rsp_valid, walk_req_valid}, 3'b100);
    chk(hit_count == 0 && miss_count == 0, "R1 counters zero", {hit_count, miss_count}, 64'd0);

    do_req(16'h2, 48'h1234_5678, 12, 0, 0, "R5 first miss");
    do_req(16'h2, 48'h1234_5abc, 12, 0, 1, "R3 same page hit");
    do_req(16'h3, 48'h1234_5000, 12, 0, 0, "R3 other asid miss");
    do_req(16'h2, 48'h1234_6000, 12, 0, 0, "R3 other page miss");
    do_req(16'h2, 48'h1234_5004, 12, 1, 1, "R4 write hit allowed");
    do_req(16'h3, 48'h1234_5010, 12, 1, 1, "R4 write hit perm fault");

    inv(1, 0, 0, 0, 0);
    do_req(16'h2, 48'h1234_5678, 12, 0, 0, "R10 miss after inv all");
    do_req(16'h5, 48'h0077_0123, 12, 1, 0, "R4 fill perm fault");
    do_req(16'h5, 48'h0077_0fff, 12, 0, 1, "R4 faulted fill cached");
    do_req(16'h4, 48'h0009_1234, 16, 0, 0, "R3 granule 16 miss");
    do_req(16'h4, 48'h0009_ff00, 16, 0, 1, "R3 granule 16 hit");

    do_req(16'h4, 48'h8000_0000_1000, 12, 0, 0, "R6 walk error");
    do_req(16'h4, 48'h8000_0000_1000, 12, 0, 0, "R6 not inserted");

    inv(1, 0, 0, 0, 0);
    do_req(16'h6, 48'h1000, 12, 0, 0, "R8 fill a");
    do_req(16'h6, 48'h2000, 12, 0, 0, "R8 fill b");
    do_req(16'h8, 48'h1000, 12, 0, 0, "R9 fill c");
    inv(0, 0, 1, 16'h6, 48'h1000);
    do_req(16'h6, 48'h2000, 12, 0, 1, "R8 neighbour kept");
    do_req(16'h8, 48'h1000, 12, 0, 1, "R8 other asid kept");
    do_req(16'h6, 48'h1000, 12, 0, 0, "R8 page removed");
    inv(0, 1, 0, 16'h6, 0);
    do_req(16'h8, 48'h1000, 12, 0, 1, "R9 other asid kept");
    do_req(16'h6, 48'h2000, 12, 0, 0, "R9 asid removed b");

    inv(1, 0, 0, 0, 0);
    for (int i = 0; i < N; i++) do_req(16'h5, 48'(i) << 12, 12, 0, 0, "R7 fill");
    for (int i = 0; i < N; i++) do_req(16'h5, (48'(i) << 12) + 48'h8, 12, 0, 1, "R7 all cached");
    do_req(16'h5, 48'(N) << 12, 12, 0, 0, "R7 miss when full");
    do_req(16'h5, 48'(N) << 12, 12, 0, 1, "R7 new fill kept");
    for (int i = 0; i < N; i++) do_req(16'h5, 48'(i) << 12, 12, 0, 0, "R7 flushed");

    wlat = 4;
    inv(1, 0, 0, 0, 0);
    fork
      do_req(16'h9, 48'hA000, 12, 0, 0, "R10 pending");
      begin repeat (2) @(negedge clk); inv_all = 1; @(negedge clk); inv_all = 0; end
    join
    do_req(16'h9, 48'hA000, 12, 0, 0, "R10 pending fill discarded");
    fork
      do_req(16'hA, 48'hB000, 12, 0, 0, "R11 pending");
      begin repeat (2) @(negedge clk); inv_asid_en = 1; inv_asid = 16'hA; @(negedge clk); inv_asid_en = 0; end
    join
    do_req(16'hA, 48'hB000, 12, 0, 1, "R11 fill survives");
    wlat = 2;

    walk_req_ready = 0;
    fork
      do_req(16'hC, 48'hC000, 12, 0, 0, "R12 stalled walk");
      begin
        repeat (5) @(negedge clk);
        chk(walk_req_valid && !req_ready && walk_req_addr == 48'hC000, "R12 held while not ready",
            {walk_req_valid, req_ready, walk_req_addr}, {2'b10, 48'hC000});
        @(posedge clk); #1 walk_req_ready = 1;
      end
    join

    @(negedge clk);
    walk_rsp_valid = 1; walk_rsp_err = 0; walk_rsp_addr = 48'h5555_0000;
    walk_rsp_mask = gmask(12); walk_rsp_wr_ok = 1;
    @(negedge clk);
    walk_rsp_valid = 0;
    chk(!rsp_valid, "R13 stray reply no response", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    chk(!rsp_valid && req_ready && miss_count == 32'(exp_miss) && hit_count == 32'(exp_hits),
        "R13 stray reply ignored", {rsp_valid, req_ready, miss_count}, {2'b01, 32'(exp_miss)});
    do_req(16'hD, 48'hD000, 12, 0, 0, "R13 no entry from stray reply");

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule